// File: doc/BRIEF.md
# Strobe-Driven FIFO with Rewind and Half-Full Indication

This block is a single-device first-in first-out buffer of nine-bit words. Two internal pointers, one for writing and one for reading, advance on their own strobes, so the user never supplies an address. The strobes are active low and are sampled by the system clock; the clock edge that first sees a strobe low starts the access, and the edge that first sees it high again ends it. Data is presented as a value plus an output-enable rather than a tri-state pin.

Three active-low flags report the fill state: an empty flag, a full flag and a half-full flag whose set and clear points sit on different strobes, giving hysteresis. A rewind input moves the read pointer back to location zero without disturbing the write pointer, so a block of up to one buffer's worth of words written since the last clear can be read out again. Chaining several devices for width or depth is not part of this block.

Control is three small state machines. The write port machine has states W_IDLE, W_STORE (strobe low, word taken) and W_REFUSE (strobe low, word refused); transitions are W_IDLE to W_STORE or W_REFUSE on a sampled falling edge, and either back to W_IDLE on a sampled rising edge. The read port machine mirrors it with R_IDLE, R_DRIVE (output enabled) and R_REFUSE. The rewind machine has T_IDLE, T_REWIND (rewind applied, input still low) and T_REFUSE (rewind refused); it leaves T_IDLE on a falling edge of the rewind input and returns on its rising edge. The depth must be a power of two of at least 4; the intended values are 512 and 1024.

Top module: `rewind_fifo`

## Requirements
- R1: While `clear_n` is low and after its release, `empty_n` is 0, `full_n` is 1, `half_n` is 1, `dout_en` is 0 and `dout` is 0, and both pointers are at location 0, so the first word written after a clear is the first word read.
- R2: A clock edge that samples `wr_n` low after having sampled it high stores `din` when the buffer is not full; the flags reflect the new word from that edge on.
- R3: A write strobe falling edge while the buffer holds DEPTH words is refused: `full_n` stays 0 and the stored words and their order are unchanged.
- R4: A clock edge that samples `rd_n` low after high, with the buffer not empty, raises `dout_en` and presents the oldest word on `dout`; both hold until the edge that samples `rd_n` high, after which `dout_en` is 0 and `dout` is 0.
- R5: A read strobe falling edge on an empty buffer is refused: `dout_en` stays 0 and the flags do not change.
- R6: `empty_n` is 0 exactly when zero words are stored and `full_n` is 0 exactly when DEPTH words are stored; with no reads since a clear, `full_n` falls on the DEPTH-th write and rises again after a read.
- R7: `half_n` falls on the write that takes the stored count above DEPTH/2 and rises only on the edge that samples the read strobe rising (or on a rewind) when the count is at most DEPTH/2; it is 0 whenever the count exceeds DEPTH/2.
- R8: A falling edge on `rt_n` while `wr_n` and `rd_n` are both high and no access is in progress sets the read pointer to 0, leaves the write pointer alone, sets the stored count to the number of writes since the last clear (at most DEPTH) and re-evaluates all three flags from it.
- R9: A falling edge on `rt_n` while either strobe is low, or while an access is in progress, is ignored: pointers, count and flags are unchanged.
- R10: Strobe falling edges sampled while `rt_n` is low are refused, and a strobe that is already low when `clear_n` is released starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| clear_n | input | 1 | Asynchronous active-low clear of pointers, count and flags |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind of the read pointer |
| din | input | DATA_W | Word to store |
| dout | output | DATA_W | Word being read, 0 when not enabled |
| dout_en | output | 1 | High while a granted read drives `dout` |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |
| half_n | output | 1 | Active-low half-full flag with hysteresis |

## Verification
The bench runs at a depth of 8 and sweeps every pair of write count and read count, then rewinds and drains, so the half-full set point (fifth word), its clear point on the read strobe rise, and the exact-depth rewind where the write pointer has wrapped back to zero are all reached; a design that cleared half-full on the read falling edge or lost the wrap would show a wrong flag or come up empty after the rewind. Overfill and underflow are driven directly, where a design that let the pointer move would corrupt the read order or raise the output enable on an empty buffer. Rewind is pulsed while a write strobe is held low and strobes are pulsed while rewind is held low, catching a design that let either override the other, and a strobe held low across the clear release catches a design that turns that into a spurious write.

// File: rtl/rwfifo_pkg.sv
package rwfifo_pkg;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_STORE  = 2'd1,
        W_REFUSE = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        R_IDLE   = 2'd0,
        R_DRIVE  = 2'd1,
        R_REFUSE = 2'd2
    } rd_state_e;

    typedef enum logic [1:0] {
        T_IDLE   = 2'd0,
        T_REWIND = 2'd1,
        T_REFUSE = 2'd2
    } rt_state_e;

    // strobe lane numbering inside the edge sampler
    localparam int LANES  = 3;
    localparam int LN_WR  = 0;
    localparam int LN_RD  = 1;
    localparam int LN_RT  = 2;

endpackage

// File: rtl/strobe_edges.sv
module strobe_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise,
    output logic [N-1:0] low
);

    logic [N-1:0] prev;

    // The previous sample clears to "low" so that a strobe held low
    // across the release of clear_n never looks like a falling edge.
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lane
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) begin
                    prev[i] <= 1'b0;
                end else begin
                    prev[i] <= lvl_n[i];
                end
            end
            assign fall[i] = prev[i] & ~lvl_n[i];
            assign rise[i] = ~prev[i] & lvl_n[i];
            assign low[i]  = ~lvl_n[i];
        end
    endgenerate

endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
    import rwfifo_pkg::*;
(
    input  logic             clk,
    input  logic             clear_n,
    input  logic [LANES-1:0] fall,
    input  logic [LANES-1:0] rise,
    input  logic [LANES-1:0] low,
    input  logic             is_empty,
    input  logic             is_full,
    output logic             wr_accept,
    output logic             rd_accept,
    output logic             rd_done,
    output logic             rewind,
    output logic             dout_en
);

    wr_state_e wr_st, wr_nx;
    rd_state_e rd_st, rd_nx;
    rt_state_e rt_st, rt_nx;

    // ---------------- next-state logic ----------------
    always_comb begin
        wr_nx = wr_st;
        unique case (wr_st)
            W_IDLE: begin
                if (fall[LN_WR]) begin
                    wr_nx = (!low[LN_RT] && !is_full) ? W_STORE : W_REFUSE;
                end
            end
            W_STORE, W_REFUSE: begin
                if (rise[LN_WR]) wr_nx = W_IDLE;
            end
            default: wr_nx = W_IDLE;
        endcase
    end

    always_comb begin
        rd_nx = rd_st;
        unique case (rd_st)
            R_IDLE: begin
                if (fall[LN_RD]) begin
                    rd_nx = (!low[LN_RT] && !is_empty) ? R_DRIVE : R_REFUSE;
                end
            end
            R_DRIVE, R_REFUSE: begin
                if (rise[LN_RD]) rd_nx = R_IDLE;
            end
            default: rd_nx = R_IDLE;
        endcase
    end

    always_comb begin
        rt_nx = rt_st;
        unique case (rt_st)
            T_IDLE: begin
                if (fall[LN_RT]) begin
                    if (!low[LN_WR] && !low[LN_RD] &&
                        wr_st == W_IDLE && rd_st == R_IDLE) begin
                        rt_nx = T_REWIND;
                    end else begin
                        rt_nx = T_REFUSE;
                    end
                end
            end
            T_REWIND, T_REFUSE: begin
                if (rise[LN_RT]) rt_nx = T_IDLE;
            end
            default: rt_nx = T_IDLE;
        endcase
    end

    // ---------------- state registers ----------------
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            wr_st <= W_IDLE;
            rd_st <= R_IDLE;
            rt_st <= T_IDLE;
        end else begin
            wr_st <= wr_nx;
            rd_st <= rd_nx;
            rt_st <= rt_nx;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        wr_accept = (wr_st == W_IDLE) && (wr_nx == W_STORE);
        rd_accept = (rd_st == R_IDLE) && (rd_nx == R_DRIVE);
        rd_done   = (rd_st == R_DRIVE) && rise[LN_RD];
        rewind    = (rt_st == T_IDLE) && (rt_nx == T_REWIND);
        dout_en   = (rd_st == R_DRIVE);
    end

endmodule

// File: rtl/occupancy_flags.sv
module occupancy_flags #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          clear_n,
    input  logic          wr_accept,
    input  logic          rd_accept,
    input  logic          rd_done,
    input  logic          rewind,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] wr_total;
    logic [CW-1:0] wr_total_nx;
    logic          over_half;
    logic          over_half_nx;

    always_comb begin
        if (rewind) begin
            cnt_nx = wr_total;
        end else begin
            cnt_nx = count + {{AW{1'b0}}, wr_accept} - {{AW{1'b0}}, rd_accept};
        end

        wr_total_nx = wr_total;
        if (wr_accept && wr_total != FULL_C) begin
            wr_total_nx = wr_total + 1'b1;
        end

        over_half_nx = over_half;
        if (rewind) begin
            over_half_nx = (cnt_nx > HALF_C);
        end else if (wr_accept && cnt_nx > HALF_C) begin
            over_half_nx = 1'b1;
        end else if (rd_done && cnt_nx <= HALF_C) begin
            over_half_nx = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            wr_total  <= '0;
            over_half <= 1'b0;
        end else begin
            if (wr_accept) wptr <= wptr + 1'b1;
            if (rewind) begin
                rptr <= '0;
            end else if (rd_accept) begin
                rptr <= rptr + 1'b1;
            end
            count     <= cnt_nx;
            wr_total  <= wr_total_nx;
            over_half <= over_half_nx;
        end
    end

    assign empty_n = (count != '0);
    assign full_n  = (count != FULL_C);
    assign half_n  = ~over_half;

endmodule

// File: rtl/data_store.sv
module data_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              wr_accept,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_accept,
    input  logic [AW-1:0]     raddr,
    input  logic              dout_en,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata;

    // a write and a read never hit the same slot in one cycle:
    // that needs a count of 0 (read refused) or DEPTH (write refused)
    always_ff @(posedge clk) begin
        if (wr_accept) mem[waddr] <= din;
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            rdata <= '0;
        end else if (rd_accept) begin
            rdata <= mem[raddr];
        end
    end

    assign dout = dout_en ? rdata : '0;

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rwfifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);

    logic [LANES-1:0] lvl_n;
    logic [LANES-1:0] fall;
    logic [LANES-1:0] rise;
    logic [LANES-1:0] low;

    logic          wr_accept;
    logic          rd_accept;
    logic          rd_done;
    logic          rewind;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count;

    always_comb begin
        lvl_n        = '1;
        lvl_n[LN_WR] = wr_n;
        lvl_n[LN_RD] = rd_n;
        lvl_n[LN_RT] = rt_n;
    end

    strobe_edges #(.N(LANES)) u_edges (
        .clk     (clk),
        .clear_n (clear_n),
        .lvl_n   (lvl_n),
        .fall    (fall),
        .rise    (rise),
        .low     (low)
    );

    port_ctrl u_ctrl (
        .clk       (clk),
        .clear_n   (clear_n),
        .fall      (fall),
        .rise      (rise),
        .low       (low),
        .is_empty  (~empty_n),
        .is_full   (~full_n),
        .wr_accept (wr_accept),
        .rd_accept (rd_accept),
        .rd_done   (rd_done),
        .rewind    (rewind),
        .dout_en   (dout_en)
    );

    occupancy_flags #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .clear_n   (clear_n),
        .wr_accept (wr_accept),
        .rd_accept (rd_accept),
        .rd_done   (rd_done),
        .rewind    (rewind),
        .wptr      (wptr),
        .rptr      (rptr),
        .count     (count),
        .empty_n   (empty_n),
        .full_n    (full_n),
        .half_n    (half_n)
    );

    data_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .clear_n   (clear_n),
        .wr_accept (wr_accept),
        .waddr     (wptr),
        .din       (din),
        .rd_accept (rd_accept),
        .raddr     (rptr),
        .dout_en   (dout_en),
        .dout      (dout)
    );

endmodule

// File: rtl/rwfifo_checker.sv
module rwfifo_checker #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input logic          clk,
    input logic          clear_n,
    input logic          wr_n,
    input logic          rd_n,
    input logic          dout_en,
    input logic          empty_n,
    input logic          full_n,
    input logic          half_n,
    input logic [CW-1:0] count,
    input logic [AW-1:0] wptr,
    input logic [AW-1:0] rptr,
    input logic          rewind
);

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!clear_n)
        !(!empty_n && !full_n));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!clear_n)
        count <= CW'(DEPTH));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (!full_n && $fell(wr_n) && rd_n) |=> !full_n);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (!empty_n && $fell(rd_n)) |=> !dout_en);

    // R4
    out_disabled_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (rd_n && $past(rd_n)) |-> !dout_en);

    // R7
    over_half_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (count > CW'(DEPTH / 2)) |-> !half_n);

    // R7
    half_release_chk: assert property (@(posedge clk) disable iff (!clear_n)
        ($rose(half_n) && !$past(rewind)) |-> ($past(rd_n) && !$past(rd_n, 2)));

    // R8
    rewind_ptr_chk: assert property (@(posedge clk) disable iff (!clear_n)
        rewind |=> (rptr == '0) && $stable(wptr));

endmodule

bind rewind_fifo rwfifo_checker #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .clear_n (clear_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .dout_en (dout_en),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n),
    .count   (count),
    .wptr    (wptr),
    .rptr    (rptr),
    .rewind  (rewind)
);

// File: tb/sim_rewind_fifo.sv
module sim_rewind_fifo;

    localparam int DW    = 9;
    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;

    logic          clk = 1'b0;
    logic          clear_n = 1'b0;
    logic          wr_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          rt_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          empty_n;
    logic          full_n;
    logic          half_n;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int q[$];
    int hist[$];
    bit half_m = 0;

    always #10 clk = ~clk;

    rewind_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .clear_n(clear_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_en(dout_en),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_flags(input string tag);
        chk(tag, "empty_n", int'(empty_n), int'(q.size() != 0));
        chk(tag, "full_n",  int'(full_n),  int'(q.size() != DEPTH));
        chk(tag, "half_n",  int'(half_n),  int'(!half_m));
    endtask

    task automatic do_clear();
        tick();
        clear_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        tick(); tick();
        clear_n = 1'b1;
        tick();
        q.delete(); hist.delete(); half_m = 0;
    endtask

    task automatic model_write(input int d);
        if (q.size() < DEPTH) begin
            q.push_back(d);
            if (hist.size() < DEPTH) hist.push_back(d);
            if (q.size() > HALF) half_m = 1;
        end
    endtask

    task automatic wr_op(input int d, input bit allow);
        tick();
        din = d[DW-1:0]; wr_n = 1'b0;
        tick();
        wr_n = 1'b1;
        tick();
        if (allow) model_write(d);
    endtask

    task automatic rd_op(input bit allow);
        bit granted;
        int exp_d;
        granted = allow && (q.size() > 0);
        exp_d = granted ? q[0] : 0;
        tick();
        rd_n = 1'b0;
        tick();
        chk(granted ? "R4" : "R5", "dout_en while low", int'(dout_en), int'(granted));
        chk(granted ? "R4" : "R5", "dout while low", int'(dout), exp_d);
        rd_n = 1'b1;
        tick();
        chk("R4", "dout_en after rise", int'(dout_en), 0);
        chk("R4", "dout after rise", int'(dout), 0);
        if (granted) begin
            void'(q.pop_front());
            if (q.size() <= HALF) half_m = 0;
        end
    endtask

    task automatic rt_op(input bit allow);
        tick();
        rt_n = 1'b0;
        tick(); tick();
        rt_n = 1'b1;
        tick();
        if (allow) begin
            q = hist;
            half_m = (q.size() > HALF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: clear state
        tick();
        chk("R1", "empty_n in clear", int'(empty_n), 0);
        chk("R1", "full_n in clear", int'(full_n), 1);
        chk("R1", "half_n in clear", int'(half_n), 1);
        chk("R1", "dout_en in clear", int'(dout_en), 0);
        do_clear();
        check_flags("R1");
        chk("R1", "dout after clear", int'(dout), 0);

        // R2 R3 R6 R7: overfill, then drain in order, then underflow (R5)
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr_op((i * 53 + 11) & 511, 1'b1);
            check_flags(i < DEPTH ? "R6" : "R3");
        end
        for (int i = 0; i < DEPTH; i++) begin
            rd_op(1'b1);
            check_flags("R7");
        end
        rd_op(1'b1);
        check_flags("R5");

        // Sweep: every write count w, every read count r <= w, then rewind and drain
        for (int w = 0; w <= DEPTH; w++) begin
            for (int r = 0; r <= w; r++) begin
                do_clear();
                for (int i = 0; i < w; i++) begin
                    wr_op((w * 31 + i * 7 + r * 3) & 511, 1'b1);
                    check_flags("R2");
                end
                for (int i = 0; i < r; i++) begin
                    rd_op(1'b1);
                    check_flags("R7");
                end
                rt_op(1'b1);
                check_flags("R8");
                for (int i = 0; i < w; i++) rd_op(1'b1);
                check_flags("R8");
            end
        end

        // R9: rewind pulse while a write strobe is held low is ignored
        do_clear();
        for (int i = 0; i < 3; i++) wr_op(100 + i, 1'b1);
        rd_op(1'b1); rd_op(1'b1);
        tick();
        din = 9'd200; wr_n = 1'b0;
        tick();
        model_write(200);
        rt_n = 1'b0;
        tick(); tick();
        rt_n = 1'b1;
        tick();
        wr_n = 1'b1;
        tick();
        check_flags("R9");
        rd_op(1'b1); rd_op(1'b1);
        check_flags("R9");

        // R9: rewind with the read strobe held low is ignored
        do_clear();
        for (int i = 0; i < 6; i++) wr_op(300 + i, 1'b1);
        rd_op(1'b1); rd_op(1'b1);
        tick();
        rd_n = 1'b0;
        tick();
        chk("R9", "read data before rewind", int'(dout), q[0]);
        rt_n = 1'b0;
        tick();
        rt_n = 1'b1;
        tick();
        rd_n = 1'b1;
        tick();
        void'(q.pop_front());
        if (q.size() <= HALF) half_m = 0;
        check_flags("R9");
        rd_op(1'b1);

        // R10: strobes while rewind is held low are refused
        do_clear();
        for (int i = 0; i < 5; i++) wr_op(400 + i, 1'b1);
        rd_op(1'b1);
        tick();
        rt_n = 1'b0;
        tick();
        q = hist; half_m = (q.size() > HALF);
        din = 9'd77; wr_n = 1'b0;
        tick();
        wr_n = 1'b1;
        tick();
        rd_n = 1'b0;
        tick();
        chk("R10", "dout_en with rewind low", int'(dout_en), 0);
        rd_n = 1'b1;
        tick();
        rt_n = 1'b1;
        tick();
        check_flags("R10");
        for (int i = 0; i < 5; i++) rd_op(1'b1);
        check_flags("R10");

        // R10: strobe held low across clear release starts nothing
        tick();
        clear_n = 1'b0; wr_n = 1'b0; din = 9'd5;
        tick(); tick();
        clear_n = 1'b1;
        tick(); tick();
        wr_n = 1'b1;
        tick();
        q.delete(); hist.delete(); half_m = 0;
        check_flags("R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule